// File: doc/BRIEF.md
# DRAM/SDRAM Refresh Timer and Controller

This block keeps one DRAM or SDRAM bank refreshed under the control of a single 24-bit configuration register. The register carries an enable, a mode select, an encoded precharge time, an encoded minimum refresh cycle time and an 11-bit interval value. In periodic mode a down-counter raises a refresh request every interval. The memory access logic grants the request when the bus is free. The block then issues a precharge-all command, waits the programmed precharge time, issues an auto-refresh command, waits the minimum cycle time and pulses a completion strobe.

In self-refresh mode the block drops the clock-enable and holds it low, so the device refreshes itself. Periodic requests and commands stop until the mode is cleared. A clock-gating input restricts the SDRAM clock enable to cycles where memory is in use.

Top module: `sdram_refresh_ctrl`

## Requirements
- R1: After reset the register reads 0xAC0000, ref_req, cmd_pre, cmd_ref and ref_done are 0, and cke is 1.
- R2: A write through cfg_wr stores cfg_wdata into the register, except bits 15:11, which always read 0. Field layout: bit 23 enable, bit 22 mode (0 periodic, 1 self refresh), bits 21:20 precharge code, bits 19:18 cycle code, bits 10:0 interval value N.
- R3: While enabled in periodic mode, ref_req rises every 2049 - N clock cycles. A register write restarts the interval, with the first request 2049 - N cycles after the write edge.
- R4: ref_req stays high until ref_gnt is sampled high while the controller is idle. Only one request is ever pending, and a grant with no request pending has no effect.
- R5: cmd_pre pulses for one cycle in the cycle after the grant edge, and ref_req is low in that cycle. cmd_ref pulses P cycles after cmd_pre, where P is 2, 3, 4 or 4 for precharge codes 00, 01, 10 and 11.
- R6: ref_done pulses for one cycle, 4 + C cycles after cmd_ref, where C is the cycle code.
- R7: Clearing the enable stops the interval counter so that no new request appears. A refresh sequence already under way still completes with cmd_ref and ref_done.
- R8: With enable and mode both set, cke goes low one cycle after the write and stays low. No request or command is issued while cke is low. Clearing the mode returns cke to 1.
- R9: sclk_en is 0 while cke is low. Otherwise it is 1 when sclk_gate is 0, or when mem_access is 1, or while a refresh sequence runs. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 24 | Register write data |
| cfg_q | output | 24 | Current register value |
| ref_gnt | input | 1 | Grant from the memory access logic |
| sclk_gate | input | 1 | Enables clock gating outside access cycles |
| mem_access | input | 1 | High while an SDRAM access cycle is in progress |
| ref_req | output | 1 | Refresh request pending |
| cmd_pre | output | 1 | One-cycle precharge-all command |
| cmd_ref | output | 1 | One-cycle auto-refresh command |
| ref_done | output | 1 | One-cycle completion strobe |
| cke | output | 1 | SDRAM clock enable, low in self refresh |
| sclk_en | output | 1 | SDRAM clock run enable |

## Verification
A counter that reloads with a wrong value, or off by one, shifts the spacing of ref_req edges. This shows within a single interval, at most a few tens of cycles for the programmed values used. A wrong sequencer state or timer load moves cmd_ref or ref_done by whole cycles relative to cmd_pre within one refresh sequence. A lost or duplicated pending flag shows either as a dropped request before the grant or as an immediate second request after it. A stuck mode state shows as cke or sclk_en held at the wrong level on the cycle after the register write.

// File: rtl/sdram_refresh_ctrl.sv
module sdram_refresh_ctrl #(
  parameter logic [23:0] RST_CFG = 24'hAC0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [23:0] cfg_wdata,
  output logic [23:0] cfg_q,
  input  logic        ref_gnt,
  input  logic        sclk_gate,
  input  logic        mem_access,
  output logic        ref_req,
  output logic        cmd_pre,
  output logic        cmd_ref,
  output logic        ref_done,
  output logic        cke,
  output logic        sclk_en
);
  localparam int NW = 11;
  localparam int CW = NW + 1;
  localparam logic [CW-1:0] SPAN = CW'(1) << NW;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_RC, ST_SELF} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    tmr;
  logic          pend;

  wire          en      = cfg_q[23];
  wire          self_md = cfg_q[22];
  wire [1:0]    trp_cd  = cfg_q[21:20];
  wire [1:0]    trc_cd  = cfg_q[19:18];
  wire [2:0]    trp_clk = (trp_cd == 2'b00) ? 3'd2 : (trp_cd == 2'b01) ? 3'd3 : 3'd4;
  wire [2:0]    trc_clk = 3'd4 + {1'b0, trc_cd};
  wire [CW-1:0] reload  = SPAN - {1'b0, cfg_q[NW-1:0]};
  wire [CW-1:0] wr_load = SPAN - {1'b0, cfg_wdata[NW-1:0]};

  wire go_self = (st == ST_IDLE) && en && self_md;
  wire go_ref  = (st == ST_IDLE) && pend && ref_gnt && !go_self;
  wire expire  = !cfg_wr && en && !self_md && (st != ST_SELF) && (cnt == '0);

  assign ref_req = pend;
  assign cke     = (st != ST_SELF);
  assign sclk_en = cke && (!sclk_gate || mem_access || st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= RST_CFG;
    end else if (cfg_wr) begin
      cfg_q <= {cfg_wdata[23:16], 5'b0, cfg_wdata[10:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= SPAN - {1'b0, RST_CFG[NW-1:0]};
    end else if (cfg_wr) begin
      cnt <= wr_load;
    end else if (en && !self_md && st != ST_SELF) begin
      cnt <= (cnt == '0) ? reload : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend <= 1'b0;
    else if (go_ref || go_self) pend <= 1'b0;
    else if (expire)           pend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      tmr      <= '0;
      cmd_pre  <= 1'b0;
      cmd_ref  <= 1'b0;
      ref_done <= 1'b0;
    end else begin
      cmd_pre  <= 1'b0;
      cmd_ref  <= 1'b0;
      ref_done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (go_self) begin
            st <= ST_SELF;
          end else if (go_ref) begin
            st      <= ST_PRE;
            tmr     <= trp_clk - 3'd1;
            cmd_pre <= 1'b1;
          end
        end
        ST_PRE: begin
          if (tmr == '0) begin
            st      <= ST_RC;
            tmr     <= trc_clk - 3'd1;
            cmd_ref <= 1'b1;
          end else begin
            tmr <= tmr - 3'd1;
          end
        end
        ST_RC: begin
          if (tmr == '0) begin
            st       <= ST_IDLE;
            ref_done <= 1'b1;
          end else begin
            tmr <= tmr - 3'd1;
          end
        end
        default: begin
          if (!(en && self_md)) st <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/sdram_refresh_ctrl_chk.sv
module sdram_refresh_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_gnt,
  input logic ref_req,
  input logic cmd_pre,
  input logic cmd_ref,
  input logic cke,
  input logic sclk_en
);
  a_r5_cmd_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_pre && cmd_ref));

  a_r5_pre_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre |=> !cmd_pre);

  a_r6_ref_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ref |=> !cmd_ref);

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> (ref_req || !cke));

  a_r4_req_taken: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre |-> !ref_req);

  a_r8_self_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (!cmd_pre && !cmd_ref && !ref_req));

  a_r9_sclk_self: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> !sclk_en);
endmodule

bind sdram_refresh_ctrl sdram_refresh_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
  .cmd_pre(cmd_pre), .cmd_ref(cmd_ref), .cke(cke), .sclk_en(sclk_en)
);

// File: tb/sdram_refresh_ctrl_tb.sv
`timescale 1ns/1ps
module sdram_refresh_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [23:0] cfg_wdata = '0;
  logic [23:0] cfg_q;
  logic ref_gnt = 1'b0, sclk_gate = 1'b0, mem_access = 1'b0;
  logic ref_req, cmd_pre, cmd_ref, ref_done, cke, sclk_en;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  sdram_refresh_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .ref_gnt(ref_gnt), .sclk_gate(sclk_gate), .mem_access(mem_access),
    .ref_req(ref_req), .cmd_pre(cmd_pre), .cmd_ref(cmd_ref), .ref_done(ref_done),
    .cke(cke), .sclk_en(sclk_en)
  );

  localparam int NV = 4;
  localparam int V_CNT [NV] = '{2020, 2000, 1990, 2030};
  localparam int V_TRP [NV] = '{0, 1, 2, 3};
  localparam int V_TRC [NV] = '{3, 0, 2, 1};
  localparam int E_PER [NV] = '{29, 49, 59, 19};
  localparam int E_TRP [NV] = '{2, 3, 4, 4};
  localparam int E_TRC [NV] = '{7, 4, 6, 5};

  task automatic tick();
    @(posedge clk); #1; cyc++;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_gnt = 1'b0; cfg_wr = 1'b0; mem_access = 1'b0; sclk_gate = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1; tick();
  endtask

  task automatic wr(input logic [23:0] v);
    cfg_wdata = v; cfg_wr = 1'b1; tick(); cfg_wr = 1'b0;
  endtask

  function automatic logic [23:0] mk(input bit en, input bit sm, input int trp, input int trc, input int n);
    return {en, sm, 2'(trp), 2'(trc), 2'b00, 5'b0, 11'(n)};
  endfunction

  task automatic wait_sig(input int which, output int n);
    n = 0;
    while (n < 5000) begin
      if ((which == 0 && ref_req) || (which == 1 && cmd_ref) || (which == 2 && ref_done)) break;
      tick(); n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, r1;
    bit seen;
    do_reset();
    // R1 reset state
    chk(cfg_q == 24'hAC0000, "R1 cfg_q", int'(cfg_q), 'hAC0000);
    chk(!ref_req && !cmd_pre && !cmd_ref && !ref_done, "R1 outputs idle", int'(ref_req), 0);
    chk(cke == 1'b1, "R1 cke", int'(cke), 1);
    // R4 grant without request ignored
    ref_gnt = 1'b1; seen = 0;
    repeat (20) begin tick(); if (cmd_pre) seen = 1; end
    ref_gnt = 1'b0;
    chk(!seen, "R4 grant with no request", int'(seen), 0);
    // R9 gating
    sclk_gate = 1'b1; tick();
    chk(sclk_en == 1'b0, "R9 gated idle", int'(sclk_en), 0);
    mem_access = 1'b1; tick();
    chk(sclk_en == 1'b1, "R9 access", int'(sclk_en), 1);
    mem_access = 1'b0;
    // R2 reserved bits
    wr(24'h3CFFFF);
    chk(cfg_q == 24'h3C07FF, "R2 reserved bits zero", int'(cfg_q), 'h3C07FF);

    // R3 R5 R6 table
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(mk(1, 0, V_TRP[i], V_TRC[i], V_CNT[i]));
      wait_sig(0, n);
      r1 = cyc;
      ref_gnt = 1'b1; tick(); ref_gnt = 1'b0;
      chk(cmd_pre && !ref_req, "R5 precharge after grant", int'(cmd_pre), 1);
      tick(); n = 1;
      while (!cmd_ref && n < 20) begin tick(); n++; end
      chk(n == E_TRP[i], "R5 precharge to refresh", n, E_TRP[i]);
      tick(); n = 1;
      while (!ref_done && n < 20) begin tick(); n++; end
      chk(n == E_TRC[i], "R6 refresh to done", n, E_TRC[i]);
      wait_sig(0, n);
      chk(cyc - r1 == E_PER[i], "R3 request interval", cyc - r1, E_PER[i]);
    end

    // R4 request held, single pending
    do_reset();
    wr(mk(1, 0, 0, 0, 2040));
    wait_sig(0, n);
    seen = 0;
    repeat (40) begin tick(); if (!ref_req) seen = 1; end
    chk(!seen, "R4 request held until grant", int'(seen), 0);
    ref_gnt = 1'b1; tick(); ref_gnt = 1'b0;
    chk(!ref_req && cmd_pre, "R4 single pending consumed", int'(ref_req), 0);

    // R7 disable mid-sequence
    do_reset();
    wr(mk(1, 0, 2, 3, 2040));
    wait_sig(0, n);
    ref_gnt = 1'b1; tick(); ref_gnt = 1'b0;
    wr(mk(0, 0, 2, 3, 2040));
    wait_sig(1, n);
    chk(cmd_ref == 1'b1, "R7 refresh finishes after disable", int'(cmd_ref), 1);
    wait_sig(2, n);
    chk(ref_done == 1'b1, "R7 done after disable", int'(ref_done), 1);
    seen = 0;
    repeat (100) begin tick(); if (ref_req) seen = 1; end
    chk(!seen, "R7 no request while disabled", int'(seen), 0);

    // R8 self refresh
    do_reset();
    sclk_gate = 1'b0;
    wr(mk(1, 1, 0, 0, 2040));
    tick();
    chk(cke == 1'b0, "R8 cke low in self refresh", int'(cke), 0);
    chk(sclk_en == 1'b0, "R9 clock off in self refresh", int'(sclk_en), 0);
    seen = 0;
    repeat (60) begin tick(); if (cke || ref_req || cmd_pre || cmd_ref) seen = 1; end
    chk(!seen, "R8 held quiet", int'(seen), 0);
    wr(mk(1, 0, 0, 0, 2040));
    tick();
    chk(cke == 1'b1, "R8 cke restored", int'(cke), 1);
    chk(sclk_en == 1'b1, "R9 ungated clock on", int'(sclk_en), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule